// File: doc/BRIEF.md
# Static Memory Access Sequencer

This block runs a single read or write cycle on an external asynchronous memory bus. An internal requester raises a request with the access direction and four cycle counts: setup, pulse, hold and data-float. The sequencer then walks the access through its phases. It drives an active-low chip select, read strobe and write strobe, and reports completion with a one-cycle done pulse.

Two direction bits choose which signal sets the pulse window. When the strobe controls the access, chip select covers the whole access and the strobe is low only for the pulse. When chip select controls it, the roles swap. A two-bit wait mode sets how the external active-low wait pin is used. It can be ignored, it can freeze the pulse while asserted, or it can hold the end of the pulse until the device reports ready. The pin always passes through a two-flop synchroniser before use. After a read, a float-busy flag marks the bus as still being released by the device. An optimisation input lets a following access start during that window, and delays only a write's pulse until the window closes.

Top module: `smc_access_seq`

## Requirements
- R1: While reset is held, and after it, with no request pending, cs_n, rd_n and we_n are high and acc_done and float_busy are low.
- R2: Read with rd_ctl_strobe=1: cs_n is low for S+P'+H' cycles and rd_n is low for P' cycles, where P' = max(P,1) and H' is the effective hold. we_n stays high.
- R3: Read with rd_ctl_strobe=0: cs_n is low for P' cycles and rd_n is low for S+P'+H' cycles.
- R4: Writes follow R2/R3 with wr_ctl_strobe and we_n in place of rd_ctl_strobe and rd_n. rd_n stays high, and rd_n and we_n are never low together.
- R5: acc_grant is high in the idle cycle in which a request is taken. acc_done is high for exactly one cycle, the last low cycle of the access envelope.
- R6: With rdy_mode 00 (off) or 01 (reserved), the wait pin has no effect on any phase length.
- R7: With rdy_mode 10 (freeze), each clock edge at which the synchronised wait is low during the pulse adds one pulse cycle. The access then resumes where it stopped.
- R8: With rdy_mode 11 (ready), the pulse stays in its last cycle while the synchronised wait is low, and ends in the first cycle in which it is high.
- R9: The wait pin is evaluated only in the pulse phase. Setup and hold lengths do not change when wait is low during them.
- R10: With rdy_mode 10 or 11, a programmed hold of 0 is raised to 1. With 00 or 01, a hold of 0 gives no hold cycle.
- R11: After a read's pulse ends, float_busy is high for exactly F cycles, starting in the next cycle. Writes and F=0 leave it low.
- R12: With float_skip_en=0, no request is granted while float_busy is high.
- R13: With float_skip_en=1, a request may be granted while float_busy is high. A write's pulse is then deferred, so cs_n and we_n are never low together while float_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | input | 1 | Access request, held until acc_grant |
| acc_write | input | 1 | 1 write, 0 read |
| acc_setup | input | CW | Setup cycle count |
| acc_pulse | input | CW | Pulse cycle count (0 treated as 1) |
| acc_hold | input | CW | Hold cycle count |
| acc_float | input | CW | Data-float cycles after a read |
| rd_ctl_strobe | input | 1 | 1: read strobe times reads, 0: chip select does |
| wr_ctl_strobe | input | 1 | 1: write strobe times writes, 0: chip select does |
| rdy_mode | input | 2 | Wait handling: 00 off, 01 reserved, 10 freeze, 11 ready |
| float_skip_en | input | 1 | Allow the next access to start during data float |
| mem_wait_n | input | 1 | External wait, active low, asynchronous |
| acc_grant | output | 1 | Request taken this cycle |
| acc_done | output | 1 | Last cycle of the access |
| float_busy | output | 1 | Bus still floating after a read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
Two functions can land in the same cycle. One is the float counter of a previous read running down. The other is the setup and float-wait of a new write taken early under the optimisation. The bench provokes this with a read that has a long float count, followed at once by a write with float_skip_en set. It also runs the same pair with the optimisation off. With the optimisation off, a grant must never coincide with float_busy. With it on, a grant during float_busy must occur, and a cycle in which chip select and write strobe are both low must never coincide with float_busy. Freeze and ready stalls are provoked by driving the wait pin at known offsets from the observed pulse start. The expected pulse length is then derived from the synchroniser's two-edge delay.

// File: rtl/smc_pkg.sv
// Shared types for the static memory access sequencer.
// Assumes: one access in flight at a time.
package smc_pkg;

    // Access phases; ordering carries no meaning
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_FWAIT = 3'd2,
        PH_PULSE = 3'd3,
        PH_HOLD  = 3'd4
    } phase_t;

    // Wait-pin handling; encoding is visible at the top port
    typedef enum logic [1:0] {
        WM_OFF    = 2'b00,
        WM_RSVD   = 2'b01,
        WM_FREEZE = 2'b10,
        WM_READY  = 2'b11
    } wmode_t;

endpackage

// File: rtl/smc_wait_sync.sv
// Synchroniser for the asynchronous active-low wait pin.
// Resets to "not waiting" so a fresh access never stalls on reset values.
// Assumes STAGES >= 2.
module smc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n_async,
    output logic wait_ok
);

    logic [STAGES-1:0] sr_q;

    // shift the raw pin through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= {sr_q[STAGES-2:0], wait_n_async};
    end

    assign wait_ok = sr_q[STAGES-1];

endmodule

// File: rtl/smc_float_track.sv
// Data-float window counter. A load sets the remaining float cycles;
// busy is high while any remain. "last" flags the final busy cycle so the
// controller can release a deferred write without a dead cycle.
module smc_float_track #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy,
    output logic          last
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] rem_q;

    // reload on a read's pulse end, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)             rem_q <= '0;
        else if (load)          rem_q <= load_val;
        else if (rem_q != '0)   rem_q <= rem_q - ONE;
    end

    assign busy = (rem_q != '0);
    assign last = (rem_q == ONE);

endmodule

// File: rtl/smc_phase_ctrl.sv
// Access phase controller: takes requests, latches the access parameters,
// steps through setup, optional float wait, pulse and hold, and applies the
// synchronised wait input during the pulse only.
// Assumes wait_ok is already synchronised and float_busy/float_last come
// from the float tracker.
module smc_phase_ctrl
    import smc_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_write,
    input  logic [CW-1:0] setup_in,
    input  logic [CW-1:0] pulse_in,
    input  logic [CW-1:0] hold_in,
    input  logic [CW-1:0] float_in,
    input  logic          rd_by_strobe,
    input  logic          wr_by_strobe,
    input  logic [1:0]    wmode_in,
    input  logic          skip_en,
    input  logic          wait_ok,
    input  logic          float_busy,
    input  logic          float_last,
    output logic          grant,
    output logic          done,
    output logic          float_load,
    output logic [CW-1:0] float_val,
    output phase_t        phase,
    output logic [CW-1:0] cnt,
    output logic          write_q,
    output logic          bystr_q,
    output wmode_t        wmode_q
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    phase_t        phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] pulse_q, hold_q, flt_q;
    logic [CW-1:0] pulse_eff_in, hold_eff_in;
    wmode_t        wm_in;
    logic          accept, defer_now, freeze_stall, ready_stall, pulse_end;

    // decode incoming request and the effective counts
    always_comb begin
        wm_in        = wmode_t'(wmode_in);
        accept       = (phase_q == PH_IDLE) && req && (!float_busy || skip_en);
        pulse_eff_in = (pulse_in == '0) ? ONE : pulse_in;
        hold_eff_in  = (wm_in[1] && hold_in == '0) ? ONE : hold_in;
        defer_now    = float_busy && !float_last;
    end

    // wait handling inside the pulse phase
    always_comb begin
        freeze_stall = (phase_q == PH_PULSE) && (wmode_q == WM_FREEZE) && !wait_ok;
        ready_stall  = (phase_q == PH_PULSE) && (wmode_q == WM_READY) && !wait_ok
                       && (cnt_q == ONE);
        pulse_end    = (phase_q == PH_PULSE) && (cnt_q == ONE)
                       && !freeze_stall && !ready_stall;
    end

    // next phase and counter value
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    if (setup_in != '0) begin
                        phase_d = PH_SETUP;
                        cnt_d   = setup_in;
                    end else if (req_write && defer_now) begin
                        phase_d = PH_FWAIT;
                    end else begin
                        phase_d = PH_PULSE;
                        cnt_d   = pulse_eff_in;
                    end
                end
            end
            PH_SETUP: begin
                if (cnt_q == ONE) begin
                    if (write_q && defer_now) begin
                        phase_d = PH_FWAIT;
                    end else begin
                        phase_d = PH_PULSE;
                        cnt_d   = pulse_q;
                    end
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            PH_FWAIT: begin
                if (!defer_now) begin
                    phase_d = PH_PULSE;
                    cnt_d   = pulse_q;
                end
            end
            PH_PULSE: begin
                if (pulse_end) begin
                    if (hold_q != '0) begin
                        phase_d = PH_HOLD;
                        cnt_d   = hold_q;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end else if (!freeze_stall && !ready_stall) begin
                    cnt_d = cnt_q - ONE;
                end
            end
            PH_HOLD: begin
                if (cnt_q == ONE) phase_d = PH_IDLE;
                else              cnt_d   = cnt_q - ONE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // phase and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // capture the access parameters when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            bystr_q <= 1'b1;
            wmode_q <= WM_OFF;
            pulse_q <= ONE;
            hold_q  <= '0;
            flt_q   <= '0;
        end else if (accept) begin
            write_q <= req_write;
            bystr_q <= req_write ? wr_by_strobe : rd_by_strobe;
            wmode_q <= wm_in;
            pulse_q <= pulse_eff_in;
            hold_q  <= hold_eff_in;
            flt_q   <= req_write ? '0 : float_in;
        end
    end

    assign grant      = accept;
    assign done       = ((phase_q == PH_HOLD) && (cnt_q == ONE)) || (pulse_end && hold_q == '0);
    assign float_load = pulse_end && !write_q;
    assign float_val  = flt_q;
    assign phase      = phase_q;
    assign cnt        = cnt_q;

endmodule

// File: rtl/smc_strobe_map.sv
// Maps the access phase onto chip select and the direction strobe.
// The controlling signal is low only in the pulse; the other one spans
// the whole access envelope. Outputs are decoded from registered state.
module smc_strobe_map
    import smc_pkg::*;
(
    input  phase_t phase,
    input  logic   write_q,
    input  logic   bystr_q,
    output logic   cs_n,
    output logic   rd_n,
    output logic   we_n
);

    logic env, ctl, cs_act, dir_act;

    // envelope vs pulse window selection
    always_comb begin
        env     = (phase != PH_IDLE);
        ctl     = (phase == PH_PULSE);
        cs_act  = bystr_q ? env : ctl;
        dir_act = bystr_q ? ctl : env;
        cs_n    = !cs_act;
        rd_n    = !(dir_act && !write_q);
        we_n    = !(dir_act && write_q);
    end

endmodule

// File: rtl/smc_access_seq.sv
// Top of the static memory access sequencer: one read or write access per
// request, with programmable phase counts, wait-pin handling and a
// data-float busy window. Assumes the requester holds acc_req and its
// fields stable until acc_grant.
module smc_access_seq
    import smc_pkg::*;
#(
    parameter int CW        = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_req,
    input  logic          acc_write,
    input  logic [CW-1:0] acc_setup,
    input  logic [CW-1:0] acc_pulse,
    input  logic [CW-1:0] acc_hold,
    input  logic [CW-1:0] acc_float,
    input  logic          rd_ctl_strobe,
    input  logic          wr_ctl_strobe,
    input  logic [1:0]    rdy_mode,
    input  logic          float_skip_en,
    input  logic          mem_wait_n,
    output logic          acc_grant,
    output logic          acc_done,
    output logic          float_busy,
    output logic          mem_cs_n,
    output logic          mem_rd_n,
    output logic          mem_we_n
);

    logic          wait_ok_w, busy_w, last_w, fload_w, write_w, bystr_w;
    logic [CW-1:0] fval_w, cnt_w;
    phase_t        phase_w;
    wmode_t        wmode_w;

    smc_wait_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .wait_n_async (mem_wait_n),
        .wait_ok      (wait_ok_w)
    );

    smc_float_track #(.CW(CW)) u_float (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fload_w),
        .load_val (fval_w),
        .busy     (busy_w),
        .last     (last_w)
    );

    smc_phase_ctrl #(.CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (acc_req),
        .req_write    (acc_write),
        .setup_in     (acc_setup),
        .pulse_in     (acc_pulse),
        .hold_in      (acc_hold),
        .float_in     (acc_float),
        .rd_by_strobe (rd_ctl_strobe),
        .wr_by_strobe (wr_ctl_strobe),
        .wmode_in     (rdy_mode),
        .skip_en      (float_skip_en),
        .wait_ok      (wait_ok_w),
        .float_busy   (busy_w),
        .float_last   (last_w),
        .grant        (acc_grant),
        .done         (acc_done),
        .float_load   (fload_w),
        .float_val    (fval_w),
        .phase        (phase_w),
        .cnt          (cnt_w),
        .write_q      (write_w),
        .bystr_q      (bystr_w),
        .wmode_q      (wmode_w)
    );

    smc_strobe_map u_map (
        .phase   (phase_w),
        .write_q (write_w),
        .bystr_q (bystr_w),
        .cs_n    (mem_cs_n),
        .rd_n    (mem_rd_n),
        .we_n    (mem_we_n)
    );

    assign float_busy = busy_w;

endmodule

// File: rtl/smc_access_seq_chk.sv
// Property checker for the access sequencer, bound into the top module.
module smc_access_seq_chk
    import smc_pkg::*;
#(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          we_n,
    input logic          done,
    input logic          grant,
    input logic          busy,
    input logic          skip_en,
    input phase_t        phase,
    input logic [CW-1:0] cnt,
    input logic          wait_ok,
    input wmode_t        wmode
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !we_n));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_freeze_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && wmode == WM_FREEZE && !wait_ok)
        |=> (phase == PH_PULSE && cnt == $past(cnt)));

    p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && wmode == WM_READY && !wait_ok && cnt == ONE)
        |=> (phase == PH_PULSE));

    p_grant_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !skip_en) |-> !busy);

    p_data_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |-> !busy);

endmodule

bind smc_access_seq smc_access_seq_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (mem_cs_n),
    .rd_n    (mem_rd_n),
    .we_n    (mem_we_n),
    .done    (acc_done),
    .grant   (acc_grant),
    .busy    (float_busy),
    .skip_en (float_skip_en),
    .phase   (phase_w),
    .cnt     (cnt_w),
    .wait_ok (wait_ok_w),
    .wmode   (wmode_w)
);

// File: tb/tb_smc_access_seq.sv
// Scoreboard bench: the issue task queues expected envelope and strobe
// lengths; a monitor measures low-cycle counts and compares on acc_done.
module tb_smc_access_seq;

    localparam int CW = 4;

    typedef struct packed {
        logic        w;
        logic        loose;
        logic [15:0] cs;
        logic [15:0] rd;
        logic [15:0] we;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0, acc_write = 1'b0;
    logic [CW-1:0] acc_setup = '0, acc_pulse = '0, acc_hold = '0, acc_float = '0;
    logic          rd_ctl_strobe = 1'b1, wr_ctl_strobe = 1'b1;
    logic [1:0]    rdy_mode = 2'b00;
    logic          float_skip_en = 1'b0;
    logic          mem_wait_n = 1'b1;
    logic          acc_grant, acc_done, float_busy, mem_cs_n, mem_rd_n, mem_we_n;

    int nchk = 0, nfail = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    int cs_cnt = 0, rd_cnt = 0, we_cnt = 0, busy_cnt = 0;
    int r12_viol = 0, r13_viol = 0, r13_early = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    smc_access_seq #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_write(acc_write),
        .acc_setup(acc_setup), .acc_pulse(acc_pulse), .acc_hold(acc_hold),
        .acc_float(acc_float), .rd_ctl_strobe(rd_ctl_strobe),
        .wr_ctl_strobe(wr_ctl_strobe), .rdy_mode(rdy_mode),
        .float_skip_en(float_skip_en), .mem_wait_n(mem_wait_n),
        .acc_grant(acc_grant), .acc_done(acc_done), .float_busy(float_busy),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    endtask

    // monitor: measure low cycles and compare on the done cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n) cs_cnt++;
            if (!mem_rd_n) rd_cnt++;
            if (!mem_we_n) we_cnt++;
            if (float_busy) busy_cnt++;
            if (acc_grant && float_busy) begin
                if (!float_skip_en) r12_viol++;
                else r13_early++;
            end
            if (!mem_cs_n && !mem_we_n && float_busy) r13_viol++;
            if (acc_done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e.loose)
                        check(cs_cnt >= int'(e.cs), {t, " R5 cs_n length (min)"}, cs_cnt, int'(e.cs));
                    else
                        check(cs_cnt == int'(e.cs), {t, " R5 cs_n length"}, cs_cnt, int'(e.cs));
                    check(rd_cnt == int'(e.rd), {t, " rd_n length"}, rd_cnt, int'(e.rd));
                    check(we_cnt == int'(e.we), {t, " we_n length"}, we_cnt, int'(e.we));
                end
                cs_cnt = 0; rd_cnt = 0; we_cnt = 0;
            end
        end
    end

    // driver: queue the expected lengths, then raise the request until granted
    task automatic issue(input logic w, input int s, input int p, input int h,
                         input int f, input int extra, input logic loose, input string tag);
        int pe, he, ctl, env, cs, stb;
        logic bys;
        exp_t e;
        pe  = (p == 0) ? 1 : p;
        he  = (rdy_mode[1] && h == 0) ? 1 : h;
        ctl = pe + extra;
        env = s + ctl + he;
        bys = w ? wr_ctl_strobe : rd_ctl_strobe;
        cs  = bys ? env : ctl;
        stb = bys ? ctl : env;
        e.w = w; e.loose = loose; e.cs = 16'(cs);
        e.rd = w ? 16'd0 : 16'(stb);
        e.we = w ? 16'(stb) : 16'd0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_write = w; acc_setup = CW'(s); acc_pulse = CW'(p);
        acc_hold = CW'(h); acc_float = CW'(f); acc_req = 1'b1;
        #1;
        while (!acc_grant) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 acc_req = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        do @(negedge clk); while (mem_rd_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(mem_cs_n && mem_rd_n && mem_we_n, "R1 strobes high in reset", 0, 1);
        check(!acc_done && !float_busy, "R1 done/busy low in reset", 1, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_rd_n && mem_we_n, "R1 strobes high idle", 0, 1);
        check(!acc_done && !float_busy && !acc_grant, "R1 idle outputs low", 1, 0);

        // R2: read timed by the read strobe
        issue(0, 2, 3, 1, 0, 0, 0, "R2 read s2p3h1"); drain();
        issue(0, 0, 0, 0, 0, 0, 0, "R2 read p0 -> 1"); drain();
        // R3: read timed by chip select
        rd_ctl_strobe = 1'b0;
        issue(0, 1, 2, 2, 0, 0, 0, "R3 read cs-timed"); drain();
        rd_ctl_strobe = 1'b1;
        // R4: writes under both controls
        issue(1, 1, 4, 2, 0, 0, 0, "R4 write strobe-timed"); drain();
        wr_ctl_strobe = 1'b0;
        issue(1, 3, 1, 0, 0, 0, 0, "R4 write cs-timed"); drain();
        wr_ctl_strobe = 1'b1;

        // R6: wait pin low but ignored in off and reserved modes
        mem_wait_n = 1'b0;
        repeat (3) @(negedge clk);
        rdy_mode = 2'b00;
        issue(0, 1, 3, 1, 0, 0, 0, "R6 mode off"); drain();
        rdy_mode = 2'b01;
        issue(0, 1, 3, 0, 0, 0, 0, "R6 mode reserved"); drain();
        mem_wait_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7: freeze for three sampled edges inside the pulse
        rdy_mode = 2'b10;
        issue(0, 1, 6, 1, 0, 3, 0, "R7 freeze stall");
        pulse_start();
        mem_wait_n = 1'b0;
        repeat (3) @(negedge clk);
        mem_wait_n = 1'b1;
        drain();

        // R8: ready mode, wait low before the access, released at pulse cycle 5
        rdy_mode = 2'b11;
        mem_wait_n = 1'b0;
        repeat (4) @(negedge clk);
        issue(0, 1, 3, 1, 0, 4, 0, "R8 ready extend");
        pulse_start();
        repeat (4) @(negedge clk);
        mem_wait_n = 1'b1;
        drain();

        // R9: wait low during setup (ready mode) does not stretch setup
        mem_wait_n = 1'b0;
        repeat (4) @(negedge clk);
        issue(0, 4, 4, 2, 0, 0, 0, "R9 setup unaffected");
        pulse_start();
        mem_wait_n = 1'b1;
        drain();
        // R9: wait low during hold (freeze mode) does not stretch hold
        rdy_mode = 2'b10;
        issue(0, 1, 2, 4, 0, 0, 0, "R9 hold unaffected");
        pulse_start();
        @(negedge clk);
        mem_wait_n = 1'b0;
        drain();
        mem_wait_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: hold of zero raised to one with wait enabled, kept at zero without
        issue(0, 1, 2, 0, 0, 0, 0, "R10 hold clamp freeze"); drain();
        rdy_mode = 2'b00;
        issue(0, 1, 2, 0, 0, 0, 0, "R10 hold zero off"); drain();

        // R11: float window after a read
        begin
            int n;
            issue(0, 1, 2, 1, 5, 0, 0, "R11 read float5");
            pulse_start();
            do @(negedge clk); while (!mem_rd_n);
            check(float_busy == 1'b1, "R11 busy starts after pulse", int'(float_busy), 1);
            n = 0;
            while (float_busy) begin
                n++;
                @(negedge clk);
            end
            check(n == 5, "R11 busy length", n, 5);
            drain();
        end
        busy_cnt = 0;
        issue(1, 1, 2, 1, 5, 0, 0, "R11 write no float"); drain();
        issue(0, 1, 2, 1, 0, 0, 0, "R11 read float0"); drain();
        check(busy_cnt == 0, "R11 no busy for write or F=0", busy_cnt, 0);

        // R12: no optimisation, following write waits for the float window
        float_skip_en = 1'b0;
        r12_viol = 0;
        issue(0, 1, 2, 1, 6, 0, 0, "R12 read float6");
        issue(1, 1, 2, 1, 0, 0, 0, "R12 write after float");
        drain();
        repeat (8) @(negedge clk);
        check(r12_viol == 0, "R12 grant during float", r12_viol, 0);

        // R13: optimisation on, read then read and read then write overlap float
        float_skip_en = 1'b1;
        r13_viol = 0; r13_early = 0;
        issue(0, 1, 2, 1, 6, 0, 0, "R13 read float6 a");
        issue(0, 1, 2, 1, 6, 0, 0, "R13 read during float");
        issue(1, 1, 2, 1, 0, 0, 1, "R13 write deferred");
        drain();
        repeat (8) @(negedge clk);
        check(r13_early >= 2, "R13 grants taken during float", r13_early, 2);
        check(r13_viol == 0, "R13 write pulse overlapped float", r13_viol, 0);

        report();
    end

endmodule